// File: doc/BRIEF.md
# Multi-Lane Converter Test Pattern Generator

This block sits between the sample path of a four-lane 8-bit data converter and its output serializers. While the pattern is off, it forwards the live converter words and the out-of-range flag to the four output lanes, with one register stage. While the pattern is on, it ignores the converter. It then drives every lane and the range flag from a fixed five-cycle sequence, so a receiver can check lane mapping, bit order and word alignment on the link.

Each lane has its own constant word. In every frame the lane sends that word for the first two output cycles and its bitwise inverse for the last three. The range flag alternates starting from zero. A frame counter runs freely on the output clock. The enable bit takes effect only at a frame boundary, so a frame is never cut short. The restart strobe, which also stops the data clock, holds the counter at frame position zero and blanks the outputs. If the enable is set while restart is held, every lane begins the first frame on the first cycle after release.

Top module: `lane_test_pattern`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four data outputs and `out_rng` are 0 after that edge, and the frame position returns to 0.
- R2: With the pattern inactive and no restart, each output equals the matching live input sampled at the previous clock edge.
- R3: In demux mode (`demux_sel`=1), frame positions 0 and 1 put 8'hFE on `out_qd`, 8'hFD on `out_id`, 8'hFC on `out_q` and 8'hFB on `out_i`. Positions 2, 3 and 4 put the inverses 8'h01, 8'h02, 8'h03 and 8'h04 on those lanes.
- R4: While the pattern is active, `out_rng` is 0, 1, 0, 1, 0 at frame positions 0 to 4.
- R5: A frame lasts exactly five output cycles. The position goes from 4 back to 0 and the sequence repeats unchanged.
- R6: While `restart` is high at a clock edge, all outputs are 0 after that edge and the frame position is held at 0. If `pat_en` is high at release, all lanes show frame position 0 on the first cycle after release.
- R7: If `pat_en` rises with no restart, the pattern starts on all lanes together at the next frame position 0 of the free-running counter. Live data continues until then.
- R8: If `pat_en` falls during a frame, the pattern finishes that frame. Live data resumes at the next frame position 0.
- R9: In non-demux mode (`demux_sel`=0), `out_q` and `out_i` carry the R3 sequence, `out_qd` and `out_id` are 0, and `out_rng` follows R4.
- R10: While the pattern is active, the live data and live range inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_en | input | 1 | Pattern enable from configuration |
| restart | input | 1 | Data-clock restart strobe; blanks outputs and zeroes frame position |
| demux_sel | input | 1 | 1 = demux (four lanes), 0 = non-demux (Q and I lanes only) |
| live_qd | input | 8 | Converter word for delayed Q lane |
| live_id | input | 8 | Converter word for delayed I lane |
| live_q | input | 8 | Converter word for Q lane |
| live_i | input | 8 | Converter word for I lane |
| live_rng | input | 1 | Converter out-of-range flag |
| out_qd | output | 8 | Delayed Q lane output |
| out_id | output | 8 | Delayed I lane output |
| out_q | output | 8 | Q lane output |
| out_i | output | 8 | I lane output |
| out_rng | output | 1 | Out-of-range output |

## Verification
The assertions assume that `pat_en`, `restart` and `demux_sel` are synchronous to `clk` and settle well before each rising edge. They also assume that `rst_n` is released synchronously. Under those conditions, the enable is sampled on a single defined edge and the frame position is never disturbed mid-cycle. The bench changes every input only on the falling clock edge. It keeps restart and reset pulses at least one full cycle wide. It toggles `demux_sel` and `pat_en` at arbitrary frame positions, so boundary gating and lane blanking are reached in every phase.

// File: rtl/tpg_pkg.sv
// Shared constants for the lane test pattern generator.
// Assumes four lanes ordered Qd, Id, Q, I; the lane index sets each lane's word.
package tpg_pkg;
    localparam int LANES     = 4;
    localparam int DW        = 8;
    localparam int FRAME     = 5;
    localparam int TRUE_LEN  = 2;
    localparam int PHW       = $clog2(FRAME);

    typedef enum int {
        LANE_QD = 0,
        LANE_ID = 1,
        LANE_Q  = 2,
        LANE_I  = 3
    } lane_e;
endpackage

// File: rtl/tpg_frame_ctr.sv
// Free-running frame position counter with a boundary-gated run flag.
// Assumes restart and pat_en are synchronous to clk. Restart zeroes the
// position and clears the run flag. The enable is sampled only at position 0.
module tpg_frame_ctr #(
    parameter int FRAME = tpg_pkg::FRAME,
    parameter int PHW   = $clog2(FRAME)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           pat_en,
    output logic [PHW-1:0] phase,
    output logic           run_now
);
    localparam logic [PHW-1:0] LAST = PHW'(FRAME - 1);

    logic running;

    // Run decision for the current cycle: new value only at frame start.
    always_comb begin
        run_now = (phase == '0) ? pat_en : running;
    end

    // Advance the frame position and latch the run decision.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase   <= '0;
            running <= 1'b0;
        end else begin
            running <= run_now;
            phase   <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && phase == LAST) |=> (phase == '0));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && phase != LAST) |=> (phase == $past(phase) + 1'b1));

    a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase <= LAST));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0 && !running));

    a_r8_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && phase != '0) |=> (running == $past(running)));
endmodule

// File: rtl/tpg_word_gen.sv
// Per-lane pattern word source. Each lane sends its own constant word in the
// first TRUE_LEN positions of a frame and the inverse of that word after them.
// The range bit alternates from 0. In non-demux mode the two delayed lanes are zero.
// Assumes FRAME is odd, so the alternation restarts at 0 every frame.
module tpg_word_gen #(
    parameter int LANES    = tpg_pkg::LANES,
    parameter int DW       = tpg_pkg::DW,
    parameter int FRAME    = tpg_pkg::FRAME,
    parameter int TRUE_LEN = tpg_pkg::TRUE_LEN,
    parameter int PHW      = $clog2(FRAME)
) (
    input  logic [PHW-1:0]            phase,
    input  logic                      demux_sel,
    output logic [LANES-1:0][DW-1:0]  pat_lane,
    output logic                      pat_rng
);
    localparam int HALF = LANES / 2;

    logic in_true;

    // Which half of the frame is being sent.
    always_comb begin
        in_true = (phase < PHW'(TRUE_LEN));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [DW-1:0] TRUE_W = {DW{1'b1}} - DW'(g + 1);
        if (g < HALF) begin : g_delayed
            // Delayed lanes: silent when not demultiplexing.
            always_comb begin
                if (!demux_sel)
                    pat_lane[g] = '0;
                else
                    pat_lane[g] = in_true ? TRUE_W : ~TRUE_W;
            end
        end else begin : g_direct
            // Direct lanes: always carry the sequence.
            always_comb begin
                pat_lane[g] = in_true ? TRUE_W : ~TRUE_W;
            end
        end
    end

    // Range flag alternation across the frame.
    always_comb begin
        pat_rng = phase[0];
    end
endmodule

// File: rtl/tpg_out_sel.sv
// Output register stage: chooses blank, pattern or live data each cycle.
// Assumes run_now already includes frame-boundary gating. Restart and reset
// force zeros, which models the stopped data clock.
module tpg_out_sel #(
    parameter int LANES = tpg_pkg::LANES,
    parameter int DW    = tpg_pkg::DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      run_now,
    input  logic                      demux_sel,
    input  logic [LANES-1:0][DW-1:0]  pat_lane,
    input  logic                      pat_rng,
    input  logic [LANES-1:0][DW-1:0]  live_lane,
    input  logic                      live_rng,
    output logic [LANES-1:0][DW-1:0]  lane_q,
    output logic                      rng_q
);
    localparam int HALF = LANES / 2;

    // Register the selected source onto the output lanes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            lane_q <= '0;
            rng_q  <= 1'b0;
        end else if (run_now) begin
            lane_q <= pat_lane;
            rng_q  <= pat_rng;
        end else begin
            lane_q <= live_lane;
            rng_q  <= live_rng;
        end
    end

    a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (lane_q == '0 && !rng_q));

    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !run_now) |=> (lane_q == $past(live_lane) && rng_q == $past(live_rng)));

    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run_now && !demux_sel) |=> (lane_q[HALF-1:0] == '0));
endmodule

// File: rtl/lane_test_pattern.sv
// Top of the lane test pattern generator. It ties together the frame counter,
// the pattern word source and the output register. Lane order inside the
// packed vectors is Qd, Id, Q, I (index 0 to 3).
// Assumes all control inputs are synchronous to clk.
module lane_test_pattern #(
    parameter int DW       = tpg_pkg::DW,
    parameter int FRAME    = tpg_pkg::FRAME,
    parameter int TRUE_LEN = tpg_pkg::TRUE_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pat_en,
    input  logic          restart,
    input  logic          demux_sel,
    input  logic [DW-1:0] live_qd,
    input  logic [DW-1:0] live_id,
    input  logic [DW-1:0] live_q,
    input  logic [DW-1:0] live_i,
    input  logic          live_rng,
    output logic [DW-1:0] out_qd,
    output logic [DW-1:0] out_id,
    output logic [DW-1:0] out_q,
    output logic [DW-1:0] out_i,
    output logic          out_rng
);
    import tpg_pkg::*;

    localparam int PH_W = $clog2(FRAME);

    logic [PH_W-1:0]            phase;
    logic                       run_now;
    logic [LANES-1:0][DW-1:0]   pat_lane;
    logic                       pat_rng;
    logic [LANES-1:0][DW-1:0]   live_lane;
    logic [LANES-1:0][DW-1:0]   lane_q;
    logic                       rng_q;

    // Pack the live lanes in index order.
    always_comb begin
        live_lane[LANE_QD] = live_qd;
        live_lane[LANE_ID] = live_id;
        live_lane[LANE_Q]  = live_q;
        live_lane[LANE_I]  = live_i;
    end

    tpg_frame_ctr #(.FRAME(FRAME), .PHW(PH_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pat_en  (pat_en),
        .phase   (phase),
        .run_now (run_now)
    );

    tpg_word_gen #(.LANES(LANES), .DW(DW), .FRAME(FRAME), .TRUE_LEN(TRUE_LEN), .PHW(PH_W)) u_gen (
        .phase     (phase),
        .demux_sel (demux_sel),
        .pat_lane  (pat_lane),
        .pat_rng   (pat_rng)
    );

    tpg_out_sel #(.LANES(LANES), .DW(DW)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .run_now   (run_now),
        .demux_sel (demux_sel),
        .pat_lane  (pat_lane),
        .pat_rng   (pat_rng),
        .live_lane (live_lane),
        .live_rng  (live_rng),
        .lane_q    (lane_q),
        .rng_q     (rng_q)
    );

    // Unpack the registered lanes onto the ports.
    always_comb begin
        out_qd  = lane_q[LANE_QD];
        out_id  = lane_q[LANE_ID];
        out_q   = lane_q[LANE_Q];
        out_i   = lane_q[LANE_I];
        out_rng = rng_q;
    end

    a_r3_true_words: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run_now && demux_sel && phase == '0)
        |=> (out_qd == ~DW'(1) && out_id == ~DW'(2) && out_q == ~DW'(3) && out_i == ~DW'(4)));

    a_r3_inverse_words: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run_now && demux_sel && phase == PH_W'(TRUE_LEN))
        |=> (out_qd == DW'(1) && out_id == DW'(2) && out_q == DW'(3) && out_i == DW'(4)));

    a_r4_rng_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run_now && phase == PH_W'(1)) |=> out_rng);

    a_r4_rng_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run_now && phase == '0) |=> !out_rng);
endmodule

// File: tb/lane_test_pattern_bench.sv
`timescale 1ns/1ps
module lane_test_pattern_bench;
    logic       clk = 1'b0;
    logic       rst_n, pat_en, restart, demux_sel, live_rng;
    logic [7:0] live_qd, live_id, live_q, live_i;
    logic [7:0] out_qd, out_id, out_q, out_i;
    logic       out_rng;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int m_ph  = 0;
    bit m_act = 1'b0;

    always #10 clk = ~clk;

    lane_test_pattern u_lane_test_pattern (
        .clk(clk), .rst_n(rst_n), .pat_en(pat_en), .restart(restart),
        .demux_sel(demux_sel), .live_qd(live_qd), .live_id(live_id),
        .live_q(live_q), .live_i(live_i), .live_rng(live_rng),
        .out_qd(out_qd), .out_id(out_id), .out_q(out_q), .out_i(out_i),
        .out_rng(out_rng)
    );

    // Expected word of lane k (0=Qd,1=Id,2=Q,3=I) at frame position ph.
    function automatic logic [7:0] exp_word(int k, int ph, bit dm);
        logic [7:0] base;
        base = 8'hFE - 8'(k);
        if (!dm && k < 2) return 8'h00;
        return (ph < 2) ? base : ~base;
    endfunction

    function automatic logic exp_rng(int ph);
        return (ph % 2) == 1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, compare at the next falling edge.
    task automatic step(bit r_n, bit rs, bit en, bit dm, logic [31:0] lv, bit lr, string tag);
        logic [31:0] e_dat;
        logic        e_rng;
        string       dt, rt;
        bit          a_now;
        rst_n = r_n; restart = rs; pat_en = en; demux_sel = dm;
        {live_qd, live_id, live_q, live_i} = lv; live_rng = lr;
        if (!r_n || rs) begin
            e_dat = '0; e_rng = 1'b0; m_ph = 0; m_act = 1'b0;
            dt = !r_n ? "R1" : "R6"; rt = dt;
        end else begin
            a_now = (m_ph == 0) ? en : m_act;
            if (a_now) begin
                e_dat = {exp_word(0, m_ph, dm), exp_word(1, m_ph, dm),
                         exp_word(2, m_ph, dm), exp_word(3, m_ph, dm)};
                e_rng = exp_rng(m_ph);
                dt = dm ? "R3" : "R9"; rt = "R4";
            end else begin
                e_dat = lv; e_rng = lr; dt = "R2"; rt = "R2";
            end
            m_act = a_now;
            m_ph  = (m_ph == 4) ? 0 : m_ph + 1;
        end
        if (tag != "") begin dt = tag; rt = tag; end
        @(negedge clk);
        check(dt, {out_qd, out_id, out_q, out_i}, e_dat);
        check(rt, {31'd0, out_rng}, {31'd0, e_rng});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit en_r, dm_r;
        void'($urandom(32'd1234));
        rst_n = 1'b0; restart = 1'b0; pat_en = 1'b0; demux_sel = 1'b1;
        {live_qd, live_id, live_q, live_i} = '0; live_rng = 1'b0;
        // R1: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, $urandom, 1, "R1");
        // R2: live pass-through
        for (int i = 0; i < 6; i++) step(1, 0, 0, 1, $urandom, 1'($urandom), "R2");
        // R6: restart held with enable set, then synchronous start
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, $urandom, 1, "R6");
        step(1, 0, 1, 1, $urandom, 1, "R6");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 1, $urandom, 1'($urandom), "");
        // R5: second frame repeats the first
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, $urandom, 1'($urandom), "R5");
        // R10: live inputs ignored
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, $urandom, 1'($urandom), "R10");
        step(1, 0, 1, 1, $urandom, 0, "");
        step(1, 0, 1, 1, $urandom, 0, "");
        // R8: disable mid-frame, frame completes before live resumes
        for (int i = 0; i < 7; i++) step(1, 0, 0, 1, $urandom, 1'($urandom), "R8");
        // R7: enable at an arbitrary frame position
        step(1, 0, 0, 1, $urandom, 0, "R7");
        for (int i = 0; i < 9; i++) step(1, 0, 1, 1, $urandom, 1'($urandom), "R7");
        // R9: non-demux after a restart
        step(1, 1, 1, 0, $urandom, 0, "R6");
        for (int i = 0; i < 10; i++) step(1, 0, 1, 0, $urandom, 1'($urandom), "R9");
        // Random mix
        en_r = 1'b1; dm_r = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(99) < 5) en_r = ~en_r;
            if ($urandom_range(99) < 2) dm_r = ~dm_r;
            step(($urandom_range(99) < 1) ? 1'b0 : 1'b1,
                 ($urandom_range(99) < 3) ? 1'b1 : 1'b0,
                 en_r, dm_r, $urandom, 1'($urandom), "");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule